// File: doc/BRIEF.md
# Paged Memory Window Address Translator

This block lets a CPU with a 16-bit address space reach a 19-bit external memory. Up to two windows are placed in the CPU's 64K space, and each one shows a selectable bank of the larger memory. When the CPU's upper address lines fall inside an enabled window, the block replaces them with bank bits and produces six extra address lines, which stand for external address bits 18 down to 13. Outside every window, the upper three lines repeat the CPU's own bits and the three top lines sit high. Unexpanded accesses therefore land in the top 64K of external memory.

Software programs the block through a byte-wide register write port. Each window has a size, a base and a bank number. A per-pin mask hands each of the six output pins either to expansion addressing or to general-purpose use. The translation is purely combinational from the CPU's upper address bits and an internal-resource hit input; only the configuration is registered. Out of reset every window is disabled and every pin is released, so all six lines read as ones and the reset vector fetch at 0xFFFE appears externally at 0x7FFFE.

Top module: `pgw_xlate`

## Requirements
- R1: While reset is held and straight after it, xa_en is 0, xa_out is 6'h3F and win_hit is 0, so a CPU fetch at 0xFFFE corresponds to external address 0x7FFFE.
- R2: A write with cfg_we high takes effect at the next rising clock edge. The register addresses are: 0 holds the window sizes (bits [2:0] for window 0, bits [6:4] for window 1); 1 and 2 hold the base page of window 0 and window 1 in bits [7:5] (CPU address bits 15..13); 3 and 4 hold the bank number of window 0 and window 1 in bits [5:0]; 5 holds the pin mask in bits [5:0]. A write to address 6 or 7 changes nothing.
- R3: The size code is 0 for disabled, 1 for 8K, 2 for 16K and 3 for 32K. Codes 4 to 7 act as disabled.
- R4: An 8K window is hit when the CPU page equals its base page, and it drives all six lines from bank bits [5:0].
- R5: A 16K window has its base page bit 0 forced to 0. It is hit when CPU page bits [2:1] match, and it drives bank bits [5:1] with CPU A13 on line 0.
- R6: The base of a 32K window is forced down to page 0, 2 or 4 (0x0000, 0x4000, 0x8000). The window covers four pages from that base and drives bank bits [5:2] with CPU A14 and A13 on lines 1 and 0.
- R7: When a 32K window is based at 0x4000 and is hit, line 1 (external bit 14) carries the inverse of CPU A14.
- R8: When windows overlap, window 0 owns the access. Window 1 still serves its pages that lie outside window 0. win_hit is one-hot or zero and marks the owner.
- R9: When int_hit is high, no window owns the access: win_hit is 0 and the lines follow the miss mapping.
- R10: When no window owns the access, lines [2:0] equal CPU A15..A13 and lines [5:3] are 1.
- R11: xa_en equals the pin mask (1 = expansion address). Each pin with mask 1 drives its translated bit, and each pin with mask 0 drives 1.
- R12: xa_out and win_hit follow cpu_page and int_hit within the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_page | input | 3 | CPU address bits 15..13 |
| int_hit | input | 1 | Access targets an internal register, RAM or EEPROM |
| xa_out | output | 6 | Expansion lines, bit 5 = external A18 down to bit 0 = external A13 |
| xa_en | output | 6 | Per-pin expansion enable |
| win_hit | output | 2 | Window that owns the current access |

## Verification
Configuration writes land on the rising edge that samples cfg_we. The bench therefore drives each write from a falling edge, drops the strobe on the next falling edge, and only then updates its shadow copy and checks the effect. The translated lines and hit flags have no register between cpu_page/int_hit and the outputs. Each address check changes those inputs on a falling edge and compares the outputs 1 ns later, well before the next rising edge, so no register stage is counted there. Expected values come from a bench function that works from the shadow copy of the written registers.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   // Number of CPU address bits that index 8K pages of the 64K space.
   localparam int PAGE_W = 3;

   typedef enum logic [1:0] {
      WSZ_OFF = 2'd0,
      WSZ_8K  = 2'd1,
      WSZ_16K = 2'd2,
      WSZ_32K = 2'd3
   } wsize_e;

   // Codes above 3 are not supported and fall back to disabled.
   function automatic wsize_e decode_size(input logic [2:0] code);
      case (code)
         3'd1:    return WSZ_8K;
         3'd2:    return WSZ_16K;
         3'd3:    return WSZ_32K;
         default: return WSZ_OFF;
      endcase
   endfunction

   // Pull an illegal base down to the nearest base legal for the size.
   function automatic logic [PAGE_W-1:0] align_base(input wsize_e sz,
                                                    input logic [PAGE_W-1:0] b);
      case (sz)
         WSZ_16K: return {b[PAGE_W-1:1], 1'b0};
         WSZ_32K: begin
            if (b[2])      return 3'd4;
            else if (b[1]) return 3'd2;
            else           return 3'd0;
         end
         default: return b;
      endcase
   endfunction

endpackage

// File: rtl/pgw_cfg_regs.sv
module pgw_cfg_regs
   import pgw_pkg::*;
#(
   parameter int N_WIN  = 2,
   parameter int DATA_W = 8,
   parameter int CFG_AW = 3,
   parameter int XA_W   = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [CFG_AW-1:0]              cfg_addr,
   input  logic [DATA_W-1:0]              cfg_wdata,
   output logic [N_WIN-1:0][2:0]          size_q,
   output logic [N_WIN-1:0][PAGE_W-1:0]   base_q,
   output logic [N_WIN-1:0][XA_W-1:0]     bank_q,
   output logic [XA_W-1:0]                mask_q
);

   localparam int SIZE_ADDR = 0;
   localparam int BASE_ADDR = 1;
   localparam int BANK_ADDR = 1 + N_WIN;
   localparam int MASK_ADDR = 1 + 2 * N_WIN;
   localparam int SZ_STRIDE = 4;

   for (genvar i = 0; i < N_WIN; i++) begin : g_win_regs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q[i] <= '0;
            base_q[i] <= '0;
            bank_q[i] <= '0;
         end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(SIZE_ADDR))
               size_q[i] <= cfg_wdata[SZ_STRIDE*i +: 3];
            if (cfg_addr == CFG_AW'(BASE_ADDR + i))
               base_q[i] <= cfg_wdata[DATA_W-1 -: PAGE_W];
            if (cfg_addr == CFG_AW'(BANK_ADDR + i))
               bank_q[i] <= cfg_wdata[XA_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(MASK_ADDR))
         mask_q <= cfg_wdata[XA_W-1:0];
   end

endmodule

// File: rtl/pgw_window.sv
module pgw_window
   import pgw_pkg::*;
#(
   parameter int XA_W = 6
) (
   input  logic [2:0]        size_code,
   input  logic [PAGE_W-1:0] base_raw,
   input  logic [XA_W-1:0]   bank,
   input  logic [PAGE_W-1:0] cpu_page,
   output logic              hit,
   output logic [XA_W-1:0]   xa
);

   wsize_e              sz;
   logic [PAGE_W-1:0]   base;
   logic [PAGE_W:0]     span_lo;
   logic [PAGE_W:0]     span_hi;
   logic                mid_base;

   assign sz       = decode_size(size_code);
   assign base     = align_base(sz, base_raw);
   assign span_lo  = {1'b0, base};
   assign span_hi  = {1'b0, base} + (PAGE_W+1)'(3);
   assign mid_base = (base == 3'd2);

   always_comb begin
      hit = 1'b0;
      xa  = bank;
      case (sz)
         WSZ_8K: begin
            hit = (cpu_page == base);
         end
         WSZ_16K: begin
            hit   = (cpu_page[PAGE_W-1:1] == base[PAGE_W-1:1]);
            xa[0] = cpu_page[0];
         end
         WSZ_32K: begin
            hit   = ({1'b0, cpu_page} >= span_lo) && ({1'b0, cpu_page} <= span_hi);
            xa[1] = cpu_page[1] ^ mid_base;
            xa[0] = cpu_page[0];
         end
         default: begin
            hit = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/pgw_pin_drive.sv
module pgw_pin_drive #(
   parameter int XA_W = 6
) (
   input  logic [XA_W-1:0] mask,
   input  logic [XA_W-1:0] xa_int,
   output logic [XA_W-1:0] xa_out,
   output logic [XA_W-1:0] xa_en
);

   for (genvar k = 0; k < XA_W; k++) begin : g_pin
      assign xa_en[k]  = mask[k];
      assign xa_out[k] = mask[k] ? xa_int[k] : 1'b1;
   end

endmodule

// File: rtl/pgw_xlate.sv
module pgw_xlate
   import pgw_pkg::*;
#(
   parameter int CPU_AW = 16,
   parameter int XA_W   = 6,
   parameter int N_WIN  = 2,
   parameter int DATA_W = 8,
   parameter int CFG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [2:0]        cpu_page,
   input  logic              int_hit,
   output logic [XA_W-1:0]   xa_out,
   output logic [XA_W-1:0]   xa_en,
   output logic [N_WIN-1:0]  win_hit
);

   localparam int HIGH_W = XA_W - PAGE_W;

   if (CPU_AW != 16)
      $error("pgw_xlate: CPU_AW must be 16 for 8K pages");
   if (HIGH_W < 1)
      $error("pgw_xlate: XA_W must exceed the page width");
   if (XA_W > DATA_W)
      $error("pgw_xlate: bank field wider than data bus");
   if (N_WIN < 1 || 4 * N_WIN > DATA_W)
      $error("pgw_xlate: size register cannot hold N_WIN fields");
   if (2 + 2 * N_WIN > (1 << CFG_AW))
      $error("pgw_xlate: CFG_AW too small for register map");

   logic [N_WIN-1:0][2:0]        size_q;
   logic [N_WIN-1:0][PAGE_W-1:0] base_q;
   logic [N_WIN-1:0][XA_W-1:0]   bank_q;
   logic [XA_W-1:0]              mask_q;
   logic [N_WIN-1:0][XA_W-1:0]   win_xa;
   logic [N_WIN-1:0]             raw_hit;
   logic [XA_W-1:0]              sel_xa;
   logic [XA_W-1:0]              miss_xa;

   pgw_cfg_regs #(
      .N_WIN (N_WIN),
      .DATA_W(DATA_W),
      .CFG_AW(CFG_AW),
      .XA_W  (XA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .size_q   (size_q),
      .base_q   (base_q),
      .bank_q   (bank_q),
      .mask_q   (mask_q)
   );

   for (genvar i = 0; i < N_WIN; i++) begin : g_win
      pgw_window #(.XA_W(XA_W)) u_win (
         .size_code(size_q[i]),
         .base_raw (base_q[i]),
         .bank     (bank_q[i]),
         .cpu_page (cpu_page),
         .hit      (raw_hit[i]),
         .xa       (win_xa[i])
      );
   end

   assign miss_xa = {{HIGH_W{1'b1}}, cpu_page};

   // Walk from the last window down so the lowest index wins an overlap.
   always_comb begin
      sel_xa  = miss_xa;
      win_hit = '0;
      for (int i = N_WIN - 1; i >= 0; i--) begin
         if (raw_hit[i] && !int_hit) begin
            win_hit    = '0;
            win_hit[i] = 1'b1;
            sel_xa     = win_xa[i];
         end
      end
   end

   pgw_pin_drive #(.XA_W(XA_W)) u_pins (
      .mask  (mask_q),
      .xa_int(sel_xa),
      .xa_out(xa_out),
      .xa_en (xa_en)
   );

endmodule

// File: rtl/pgw_xlate_chk.sv
module pgw_xlate_chk #(
   parameter int XA_W   = 6,
   parameter int N_WIN  = 2,
   parameter int DATA_W = 8,
   parameter int CFG_AW = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_we,
   input logic [CFG_AW-1:0]     cfg_addr,
   input logic [DATA_W-1:0]     cfg_wdata,
   input logic [2:0]            cpu_page,
   input logic                  int_hit,
   input logic [XA_W-1:0]       xa_out,
   input logic [XA_W-1:0]       xa_en,
   input logic [N_WIN-1:0]      win_hit,
   input logic [2:0]            w0_size,
   input logic [2:0]            w0_base
);

   localparam int MASK_ADDR = 1 + 2 * N_WIN;
   localparam int HIGH_W    = XA_W - 3;

   assert_owner_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_hit));

   assert_internal_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int_hit |-> (win_hit == '0));

   assert_released_pin_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((~xa_en & ~xa_out) == '0));

   assert_miss_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((win_hit == '0) && (xa_en == '1)) |-> (xa_out == {{HIGH_W{1'b1}}, cpu_page}));

   assert_mid_invert_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit[0] && w0_size == 3'd3 && w0_base[2:1] == 2'b01 && xa_en[1])
         |-> (xa_out[1] == ~cpu_page[1]));

   assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CFG_AW'(MASK_ADDR)) |=> (xa_en == $past(cfg_wdata[XA_W-1:0])));

endmodule

bind pgw_xlate pgw_xlate_chk #(
   .XA_W  (XA_W),
   .N_WIN (N_WIN),
   .DATA_W(DATA_W),
   .CFG_AW(CFG_AW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .cfg_wdata(cfg_wdata),
   .cpu_page (cpu_page),
   .int_hit  (int_hit),
   .xa_out   (xa_out),
   .xa_en    (xa_en),
   .win_hit  (win_hit),
   .w0_size  (size_q[0]),
   .w0_base  (base_q[0])
);

// File: tb/pgw_xlate_tb.sv
module pgw_xlate_tb;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [2:0] cpu_page = '0;
   logic       int_hit = 1'b0;
   logic [5:0] xa_out;
   logic [5:0] xa_en;
   logic [1:0] win_hit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] sh [0:5];

   always #(CLK_P/2) clk = ~clk;

   pgw_xlate u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cpu_page (cpu_page),
      .int_hit  (int_hit),
      .xa_out   (xa_out),
      .xa_en    (xa_en),
      .win_hit  (win_hit)
   );

   // Expected {win_hit, xa_out, xa_en} from the written configuration.
   function automatic logic [13:0] model(input logic [15:0] a, input logic ih);
      logic [5:0] xa;
      logic [1:0] wh;
      logic [5:0] m;
      xa = {3'b111, a[15:13]};
      wh = 2'b00;
      for (int w = 1; w >= 0; w--) begin
         logic [2:0] sz;
         logic [2:0] b;
         logic [2:0] pg;
         logic [5:0] t;
         logic       hit;
         sz  = sh[0][4*w +: 3];
         b   = sh[1+w][7:5];
         t   = sh[3+w][5:0];
         pg  = a[15:13];
         hit = 1'b0;
         case (sz)
            3'd1: hit = (pg == b);
            3'd2: begin
               b[0] = 1'b0;
               hit  = (pg[2:1] == b[2:1]);
               t[0] = a[13];
            end
            3'd3: begin
               b    = (b >= 3'd4) ? 3'd4 : ((b >= 3'd2) ? 3'd2 : 3'd0);
               hit  = (pg >= b) && ({1'b0, pg} <= {1'b0, b} + 4'd3);
               t[1] = a[14] ^ (b == 3'd2);
               t[0] = a[13];
            end
            default: hit = 1'b0;
         endcase
         if (hit && !ih) begin
            wh = 2'b01 << w;
            xa = t;
         end
      end
      m = sh[5][5:0];
      return {wh, (xa & m) | ~m, m};
   endfunction

   task automatic cfg_write(input logic [2:0] ad, input logic [7:0] d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = ad;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (ad < 3'd6) sh[ad] = d;
   endtask

   task automatic check_addr(input string req, input logic [15:0] a, input logic ih);
      logic [13:0] exp;
      logic [13:0] got;
      @(negedge clk);
      cpu_page = a[15:13];
      int_hit  = ih;
      #1;
      exp = model(a, ih);
      got = {win_hit, xa_out, xa_en};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s addr=%h ih=%0b got=%h exp=%h", req, a, ih, got, exp);
      end
   endtask

   task automatic check_lit(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 6; i++) sh[i] = 8'h00;

      // R1: state during reset
      repeat (2) @(negedge clk);
      cpu_page = 3'b111;
      #1;
      check_lit("R1 reset lines", {24'd0, xa_en, win_hit}, 32'd0);
      check_lit("R1 reset vector address", {13'd0, xa_out, 13'h1FFE}, 32'h7FFFE);
      @(negedge clk);
      rst_n = 1'b1;
      check_addr("R1 after reset", 16'hFFFE, 1'b0);
      check_lit("R1 xa_out all ones", {26'd0, xa_out}, 32'h3F);

      // R11: release all pins, miss mapping
      cfg_write(3'd5, 8'h3F);
      check_lit("R2 mask write", {26'd0, xa_en}, 32'h3F);
      check_addr("R10 miss top page", 16'hE000, 1'b0);
      check_addr("R10 miss page 2", 16'h4000, 1'b0);

      // R4: window 0 8K at page 2 bank 0x05
      cfg_write(3'd0, 8'h31);
      cfg_write(3'd1, 8'h40);
      cfg_write(3'd3, 8'h05);
      cfg_write(3'd2, 8'h00);
      cfg_write(3'd4, 8'h28);
      check_addr("R4 8K hit", 16'h4123, 1'b0);
      check_lit("R4 8K lines", {24'd0, win_hit, xa_out}, {24'd0, 2'b01, 6'h05});
      // R8: window 1 32K at 0 covers page 1 outside window 0
      check_addr("R8 window1 outside overlap", 16'h2000, 1'b0);
      check_lit("R8 window1 lines", {24'd0, win_hit, xa_out}, {24'd0, 2'b10, 6'h29});
      // R9: internal hit wins over window
      check_addr("R9 internal precedence", 16'h4000, 1'b1);

      // R5: 16K with misaligned base page 3 forced to 2
      cfg_write(3'd0, 8'h02);
      cfg_write(3'd1, 8'h60);
      cfg_write(3'd3, 8'h2B);
      check_addr("R5 16K lower page", 16'h4000, 1'b0);
      check_addr("R5 16K upper page", 16'h6000, 1'b0);
      check_lit("R5 16K line0 follows A13", {24'd0, win_hit, xa_out}, {24'd0, 2'b01, 6'h2B});

      // R7: 32K at 0x4000 (raw page 3 forced to 2) inverts A14
      cfg_write(3'd0, 8'h03);
      cfg_write(3'd3, 8'h3C);
      check_addr("R7 mid base page2", 16'h4000, 1'b0);
      check_lit("R7 line1 inverted", {26'd0, xa_out}, 32'h3C);
      check_addr("R7 mid base page4", 16'h8000, 1'b0);
      check_lit("R7 line1 inverted low", {26'd0, xa_out}, 32'h3E);
      check_addr("R7 miss keeps true A14", 16'hC000, 1'b0);

      // R6: 32K base page 7 forced to 4
      cfg_write(3'd1, 8'hE0);
      check_addr("R6 32K forced base page4", 16'h8000, 1'b0);
      check_addr("R6 32K forced base page7", 16'hE000, 1'b0);
      check_addr("R6 32K miss page3", 16'h6000, 1'b0);

      // R3: unsupported size code acts as disabled
      cfg_write(3'd0, 8'h05);
      check_addr("R3 code5 disabled", 16'hE000, 1'b0);
      check_lit("R3 no hit", {30'd0, win_hit}, 32'd0);

      // R2: write to unused address 6 changes nothing
      cfg_write(3'd6, 8'hFF);
      check_addr("R2 addr6 ignored", 16'hE000, 1'b0);

      // R11: partial mask
      cfg_write(3'd0, 8'h01);
      cfg_write(3'd5, 8'h15);
      check_addr("R11 partial mask", 16'hE000, 1'b0);

      // R12 and all: random configurations, outputs checked same cycle
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 3) == 0)
            cfg_write(3'($urandom_range(0, 7)), 8'($urandom));
         check_addr("R12 random", 16'($urandom), ($urandom_range(0, 7) == 0));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule